// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the combinational arithmetic and logic core for an 8-bit accumulator datapath. Each evaluation takes the accumulator value, a second operand, the current condition flags (zero, subtract, half-carry, carry) and a 4-bit operation code. It returns the new value, a strobe that says whether that value should be written back, and the new flags.

Every operation has its own flag rule. Some flags are forced to a constant, some are computed from the operation and some pass through unchanged. Compare produces flags without a write-back. Increment and decrement act on the second operand, which stands for the register being stepped. Decimal adjust corrects the accumulator after a binary add or subtract on packed BCD, and it chooses its direction from the subtract flag it is given.

The surrounding core decodes instructions, fetches operands and registers the outputs. It also stores the packed flag byte.

Top module: `acc_alu8`

## Requirements
- R1: Op 0 (add) returns acc+opnd and op 1 (add with carry) returns acc+opnd+C, written back. In both, Z is set when the 8-bit result is 0, N is 0, H is the carry out of bit 3 and C is the carry out of bit 7.
- R2: Op 2 (subtract) returns acc-opnd and op 3 (subtract with borrow) returns acc-opnd-C, written back. In both, Z comes from the result, N is 1, H is the borrow into bit 3 from bit 4 and C is the borrow out of bit 7.
- R3: Op 7 (compare) produces the flags of op 2. The write strobe is 0 and result_o equals acc_i.
- R4: Op 4 (AND) writes acc&opnd with Z from the result, N=0, H=1 and C=0.
- R5: Op 5 (XOR) writes acc^opnd and op 6 (OR) writes acc|opnd. Z comes from the result and N, H and C are all 0.
- R6: Op 8 (increment) writes opnd+1 with N=0 and H set when the low nibble of opnd is 0xF. Op 9 (decrement) writes opnd-1 with N=1 and H set when the low nibble of opnd is 0. C passes through unchanged for both, and Z comes from the result.
- R7: Op 10 (decimal adjust) with N=0 adds 0x60 and sets C when C is set or acc>0x99. It adds 0x06 when H is set or the low nibble of acc is >9. Both tests use the unadjusted acc. When neither 0x60 condition holds, C stays 0.
- R8: Op 10 with N=1 subtracts 0x60 when C is set and 0x06 when H is set, and C is kept. For both directions of op 10, N is kept, H is 0, Z comes from the result, and the result is written.
- R9: Op 11 (complement) writes ~acc with N=1 and H=1. Z and C are kept.
- R10: Op 12 (complement carry) inverts C. Op 13 (set carry) forces C to 1. Both clear N and H, keep Z and do not write.
- R11: Op codes 14 and 15 are empty. The write strobe is 0, result_o equals acc_i and the flags equal the input flags.
- R12: The flag nibble is ordered Z,N,H,C from bit 3 down to bit 0. freg_o carries it in bits 7..4, and its bits 3..0 are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand; the target value for increment and decrement |
| flags_i | input | 4 | Incoming flags {Z,N,H,C} |
| op_i | input | 4 | Operation code 0..15 |
| result_o | output | 8 | New value, or acc_i when the write strobe is 0 |
| wr_o | output | 1 | Write-back strobe for result_o |
| flags_o | output | 4 | Outgoing flags {Z,N,H,C} |
| freg_o | output | 8 | Packed flag byte {flags_o, 4'b0} |

## Verification
On every evaluation, the assertions check the flag rules that hold for a whole class of operations. The carry must pass through for increment, decrement and complement. The logic ops must clear N and C and have a Z that matches the result. A value that is not written back must equal the accumulator, and empty codes must hold the flags. Only the bench's reference model can show the arithmetic values and the per-nibble carry and borrow. The same holds for the two directions of decimal adjust and for the corner operands. The corner cases are 0x0F+1, 0xFF+1, 0x00-1, a borrow-in that reaches zero, BCD sums just above 0x99 and equal operands on compare.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DW = 8;
    localparam int NW = DW / 2;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_AND  = 4'd4,
        OP_XOR  = 4'd5,
        OP_OR   = 4'd6,
        OP_CMP  = 4'd7,
        OP_INC  = 4'd8,
        OP_DEC  = 4'd9,
        OP_DADJ = 4'd10,
        OP_CPL  = 4'd11,
        OP_CCF  = 4'd12,
        OP_SCF  = 4'd13,
        OP_NUL0 = 4'd14,
        OP_NUL1 = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } alu_flags_t;

    function automatic logic is_zero(input logic [DW-1:0] v);
        return (v == '0);
    endfunction

    function automatic logic uses_carry_in(input alu_op_e op);
        return (op == OP_ADC) || (op == OP_SBC);
    endfunction

    function automatic logic is_sub_class(input alu_op_e op);
        return (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
    endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import acc_alu_pkg::*;
(
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cin_i,
    input  alu_op_e       op_i,
    output logic [DW-1:0] res_o,
    output logic          hc_o,
    output logic          cy_o
);
    logic          cy_used;
    logic [DW:0]   wide;
    logic [NW:0]   low;

    always_comb begin
        cy_used = uses_carry_in(op_i) & cin_i;
        wide    = '0;
        low     = '0;
        res_o   = '0;
        hc_o    = 1'b0;
        cy_o    = 1'b0;
        if (op_i == OP_ADD || op_i == OP_ADC) begin
            wide  = {1'b0, a_i} + {1'b0, b_i} + (DW+1)'(cy_used);
            low   = {1'b0, a_i[NW-1:0]} + {1'b0, b_i[NW-1:0]} + (NW+1)'(cy_used);
            res_o = wide[DW-1:0];
            hc_o  = low[NW];
            cy_o  = wide[DW];
        end else if (is_sub_class(op_i)) begin
            wide  = {1'b0, a_i} - {1'b0, b_i} - (DW+1)'(cy_used);
            low   = {1'b0, a_i[NW-1:0]} - {1'b0, b_i[NW-1:0]} - (NW+1)'(cy_used);
            res_o = wide[DW-1:0];
            hc_o  = low[NW];
            cy_o  = wide[DW];
        end else if (op_i == OP_INC) begin
            res_o = b_i + DW'(1);
            hc_o  = &b_i[NW-1:0];
        end else if (op_i == OP_DEC) begin
            res_o = b_i - DW'(1);
            hc_o  = ~|b_i[NW-1:0];
        end
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import acc_alu_pkg::*;
(
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  alu_op_e       op_i,
    output logic [DW-1:0] res_o
);
    always_comb begin
        unique case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_CPL:  res_o = ~a_i;
            default: res_o = a_i;
        endcase
    end
endmodule

// File: rtl/alu8_dadj.sv
module alu8_dadj
    import acc_alu_pkg::*;
(
    input  logic [DW-1:0] a_i,
    input  alu_flags_t    fl_i,
    output logic [DW-1:0] res_o,
    output logic          cy_o
);
    localparam logic [DW-1:0] LO_FIX = DW'(6);
    localparam logic [DW-1:0] HI_FIX = DW'(8'h60);
    localparam logic [DW-1:0] HI_LIM = DW'(8'h99);
    localparam logic [NW-1:0] LO_LIM = NW'(9);

    logic [DW-1:0] fix;
    logic          hi_need;
    logic          lo_need;

    always_comb begin
        if (!fl_i.n) begin
            hi_need = fl_i.c || (a_i > HI_LIM);
            lo_need = fl_i.h || (a_i[NW-1:0] > LO_LIM);
        end else begin
            hi_need = fl_i.c;
            lo_need = fl_i.h;
        end
        fix   = (hi_need ? HI_FIX : '0) | (lo_need ? LO_FIX : '0);
        res_o = fl_i.n ? (a_i - fix) : (a_i + fix);
        cy_o  = hi_need;
    end
endmodule

// File: rtl/acc_alu8.sv
module acc_alu8
    import acc_alu_pkg::*;
(
    input  logic [7:0] acc_i,
    input  logic [7:0] opnd_i,
    input  logic [3:0] flags_i,
    input  logic [3:0] op_i,
    output logic [7:0] result_o,
    output logic       wr_o,
    output logic [3:0] flags_o,
    output logic [7:0] freg_o
);
    alu_op_e       op;
    alu_flags_t    fin;
    alu_flags_t    fout;
    logic [DW-1:0] ar_res, lg_res, da_res, sel;
    logic          ar_h, ar_c, da_c;

    assign op  = alu_op_e'(op_i);
    assign fin = alu_flags_t'(flags_i);

    alu8_arith u_arith (
        .a_i(acc_i), .b_i(opnd_i), .cin_i(fin.c), .op_i(op),
        .res_o(ar_res), .hc_o(ar_h), .cy_o(ar_c)
    );

    alu8_logic u_logic (
        .a_i(acc_i), .b_i(opnd_i), .op_i(op), .res_o(lg_res)
    );

    alu8_dadj u_dadj (
        .a_i(acc_i), .fl_i(fin), .res_o(da_res), .cy_o(da_c)
    );

    always_comb begin
        fout = fin;
        sel  = acc_i;
        wr_o = 1'b0;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP: begin
                sel  = ar_res;
                wr_o = (op != OP_CMP);
                fout = '{z: is_zero(ar_res), n: is_sub_class(op), h: ar_h, c: ar_c};
            end
            OP_INC, OP_DEC: begin
                sel  = ar_res;
                wr_o = 1'b1;
                fout = '{z: is_zero(ar_res), n: (op == OP_DEC), h: ar_h, c: fin.c};
            end
            OP_AND, OP_XOR, OP_OR: begin
                sel  = lg_res;
                wr_o = 1'b1;
                fout = '{z: is_zero(lg_res), n: 1'b0, h: (op == OP_AND), c: 1'b0};
            end
            OP_CPL: begin
                sel  = lg_res;
                wr_o = 1'b1;
                fout = '{z: fin.z, n: 1'b1, h: 1'b1, c: fin.c};
            end
            OP_DADJ: begin
                sel  = da_res;
                wr_o = 1'b1;
                fout = '{z: is_zero(da_res), n: fin.n, h: 1'b0,
                         c: fin.n ? fin.c : da_c};
            end
            OP_CCF:  fout = '{z: fin.z, n: 1'b0, h: 1'b0, c: ~fin.c};
            OP_SCF:  fout = '{z: fin.z, n: 1'b0, h: 1'b0, c: 1'b1};
            default: fout = fin;
        endcase
    end

    assign result_o = wr_o ? sel : acc_i;
    assign flags_o  = fout;
    assign freg_o   = {fout, 4'b0000};

    always_comb begin
        if (!$isunknown({op_i, acc_i, opnd_i, flags_i})) begin
            if (op == OP_INC || op == OP_DEC || op == OP_CPL)
                a_r6_carry_kept: assert (flags_o[0] == flags_i[0]);
            if (op == OP_AND || op == OP_XOR || op == OP_OR)
                a_r5_logic_flags: assert (flags_o[3] == (result_o == 8'h00) && !flags_o[2] && !flags_o[0]);
            if (!wr_o)
                a_r3_hold_acc: assert (result_o == acc_i);
            if (op == OP_NUL0 || op == OP_NUL1)
                a_r11_empty_op: assert (!wr_o && flags_o == flags_i);
            if (op == OP_ADD || op == OP_ADC)
                a_r1_add_clears_n: assert (!flags_o[2]);
            if (op == OP_CMP)
                a_r3_cmp_no_write: assert (!wr_o && flags_o[2]);
        end
    end
endmodule

// File: tb/acc_alu8_bench.sv
module acc_alu8_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] acc, opnd;
    logic [3:0] fl, op;
    logic [7:0] result;
    logic       wr;
    logic [3:0] flo;
    logic [7:0] freg;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    acc_alu8 u_acc_alu8 (
        .acc_i(acc), .opnd_i(opnd), .flags_i(fl), .op_i(op),
        .result_o(result), .wr_o(wr), .flags_o(flo), .freg_o(freg)
    );

    function automatic string tag_of(input int o);
        case (o)
            0, 1:  return "R1";
            2, 3:  return "R2";
            7:     return "R3";
            4:     return "R4";
            5, 6:  return "R5";
            8, 9:  return "R6";
            11:    return "R9";
            12, 13: return "R10";
            14, 15: return "R11";
            default: return "R7/R8";
        endcase
    endfunction

    // returns {we, result[7:0], z, n, h, c}
    function automatic logic [12:0] model(input int o, input int a, input int b, input logic [3:0] f);
        int z = f[3], n = f[2], h = f[1], c = f[0];
        int r = a, we = 0, s, k;
        case (o)
            0, 1: begin
                k = (o == 1) ? c : 0;
                s = a + b + k; r = s % 256; we = 1;
                n = 0; h = ((a % 16) + (b % 16) + k) > 15; c = s > 255; z = (r == 0);
            end
            2, 3, 7: begin
                k = (o == 3) ? c : 0;
                s = a - b - k; r = (s + 512) % 256; we = (o != 7);
                n = 1; h = ((a % 16) - (b % 16) - k) < 0; c = s < 0; z = (r == 0);
                if (o == 7) r = a;
                if (o == 7) z = (((s + 512) % 256) == 0);
            end
            4: begin r = a & b; we = 1; z = (r == 0); n = 0; h = 1; c = 0; end
            5: begin r = a ^ b; we = 1; z = (r == 0); n = 0; h = 0; c = 0; end
            6: begin r = a | b; we = 1; z = (r == 0); n = 0; h = 0; c = 0; end
            8: begin r = (b + 1) % 256; we = 1; z = (r == 0); n = 0; h = ((b % 16) == 15); end
            9: begin r = (b + 255) % 256; we = 1; z = (r == 0); n = 1; h = ((b % 16) == 0); end
            10: begin
                s = a;
                if (n == 0) begin
                    if (c != 0 || a > 153) begin s = s + 96; c = 1; end
                    if (h != 0 || (a % 16) > 9) s = s + 6;
                end else begin
                    if (c != 0) s = s - 96;
                    if (h != 0) s = s - 6;
                end
                r = (s + 512) % 256; we = 1; z = (r == 0); h = 0;
            end
            11: begin r = 255 - a; we = 1; n = 1; h = 1; end
            12: begin c = (c == 0); n = 0; h = 0; end
            13: begin c = 1; n = 0; h = 0; end
            default: ;
        endcase
        return {we[0], r[7:0], z[0], n[0], h[0], c[0]};
    endfunction

    task automatic apply(input int o, input int a, input int b, input logic [3:0] f, input string note);
        logic [12:0] e;
        @(posedge clk); #1;
        op = o[3:0]; acc = a[7:0]; opnd = b[7:0]; fl = f;
        e = model(o, a, b, f);
        @(negedge clk);
        checks++;
        if ({wr, result, flo} !== e || freg !== {e[3:0], 4'b0000}) begin
            errors++;
            $display("FAIL %s %s op=%0d a=%h b=%h f=%h: got wr=%b res=%h fl=%h freg=%h exp wr=%b res=%h fl=%h freg=%h (R12 packing)",
                     tag_of(o), note, o, a[7:0], b[7:0], f, wr, result, flo, freg,
                     e[12], e[11:4], e[3:0], {e[3:0], 4'b0000});
        end
    endtask

    initial begin
        acc = '0; opnd = '0; fl = '0; op = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // R12 state after reset: all-zero add gives Z only
        apply(0, 8'h00, 8'h00, 4'h0, "R12 zero add");
        apply(0, 8'h0F, 8'h01, 4'h0, "R1 half carry");
        apply(0, 8'hFF, 8'h01, 4'h0, "R1 wrap zero carry");
        apply(1, 8'h0E, 8'h01, 4'h1, "R1 adc carry in");
        apply(2, 8'h10, 8'h01, 4'h0, "R2 nibble borrow");
        apply(2, 8'h00, 8'h01, 4'h0, "R2 full borrow");
        apply(3, 8'h01, 8'h00, 4'h1, "R2 sbc to zero");
        apply(7, 8'h42, 8'h42, 4'h0, "R3 cmp equal");
        apply(7, 8'h10, 8'h20, 4'hF, "R3 cmp below");
        apply(4, 8'hF0, 8'h0F, 4'hF, "R4 and zero");
        apply(5, 8'hAA, 8'hAA, 4'hF, "R5 xor self");
        apply(6, 8'h00, 8'h80, 4'hF, "R5 or");
        apply(8, 8'h00, 8'hFF, 4'h1, "R6 inc wrap keeps C");
        apply(8, 8'h00, 8'h0F, 4'h0, "R6 inc half");
        apply(9, 8'h00, 8'h10, 4'h1, "R6 dec half");
        apply(9, 8'h00, 8'h01, 4'h0, "R6 dec to zero");
        apply(10, 8'h7D, 8'h00, 4'h0, "R7 0x45+0x38");
        apply(10, 8'h9A, 8'h00, 4'h0, "R7 above 0x99");
        apply(10, 8'h00, 8'h00, 4'h3, "R7 both flags");
        apply(10, 8'h03, 8'h00, 4'h0, "R7 no fix");
        apply(10, 8'h0C, 8'h00, 4'h6, "R8 sub half");
        apply(10, 8'hF0, 8'h00, 4'h5, "R8 sub carry");
        apply(11, 8'h5A, 8'h00, 4'h9, "R9 cpl");
        apply(12, 8'h12, 8'h00, 4'hF, "R10 ccf");
        apply(13, 8'h12, 8'h00, 4'h8, "R10 scf");
        apply(14, 8'h33, 8'h44, 4'hA, "R11 empty");
        apply(15, 8'h55, 8'h66, 4'h5, "R11 empty");
        void'($urandom(32'd24680));
        for (int i = 0; i < 3000; i++) begin
            int o  = int'($urandom_range(15, 0));
            int a  = int'($urandom_range(255, 0));
            int b  = int'($urandom_range(255, 0));
            logic [3:0] f = 4'($urandom_range(15, 0));
            apply(o, a, b, f, "random");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule